// File: doc/BRIEF.md
# Serial Peripheral Interrupt Status Hub

This block gathers the event flags of a register-mapped serial peripheral into one 32-bit sticky status register and turns them into a single level interrupt line. Software reaches three registers over a simple 32-bit register bus. These are the status register, a 32-bit per-bit enable register and a device-wide master enable. Writes to the status register toggle bits rather than clearing them. Two status bits that mirror the receive FIFO condition are set again on every bus access for as long as that condition lasts.

FIFO and transfer logic deliver single-cycle event pulses on a 32-bit vector aligned to the status bits. The receive FIFO also provides two level inputs, one for "holds data" and one for "full". The interrupt line is a register that is updated from the stored contents on every clock. Both the hardware reset and a soft-reset pulse clear all three registers.

Top module: `ih_irq_hub`

## Requirements
- R1: After the synchronous reset, the status, enable and master-enable registers all read 0 and `irq_o` is low.
- R2: The master enable lives in bit 31 of the register at byte address 0x1C, and the other bits of that register read as 0. While this bit is 0, `irq_o` is low one clock later, whatever the status and enable registers hold.
- R3: `irq_o` is a register. On every clock edge it takes the value (status AND enable is nonzero) AND master enable, so it follows a change in any of them exactly one clock later.
- R4: A write to the status register at byte address 0x20 XORs the written data into it. Each bit written as 1 flips and each bit written as 0 keeps its value.
- R5: The enable register at byte address 0x28 stores all 32 written bits and reads them back unchanged.
- R6: A 1 on bit i of `evt_pulse_i` sets status bit i, and that bit stays set until software toggles it. The positions of the six events are: rx-not-empty 8, rx-full 4, rx-overrun 5, tx-empty 2, tx-underrun 3 and tx-half-empty 6. If an event and a status-write toggle hit the same bit in the same cycle, the bit ends up 1.
- R7: On any bus read or write, status bit 8 is set if `rx_nonempty_i` is high and status bit 4 is set if `rx_full_i` is high. This happens after the toggle of that access, so neither bit can be cleared by a write while its level is high.
- R8: A one-cycle pulse on `soft_rst_i` clears the status, enable and master-enable registers, and it takes priority over writes and events in the same cycle.
- R9: Read data appears on `bus_rdata_o` on the clock edge after the read strobe. A read of any byte address other than 0x1C, 0x20 or 0x28 (including misaligned ones) returns 0.
- R10: With no bus access, no event and no soft reset, the status register and `irq_o` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| soft_rst_i | input | 1 | One-cycle soft reset of all three registers |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | ADDR_W | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| evt_pulse_i | input | 32 | Event pulses, bit-aligned with status |
| rx_nonempty_i | input | 1 | Receive FIFO holds data (level) |
| rx_full_i | input | 1 | Receive FIFO full (level) |
| irq_o | output | 1 | Level interrupt output |

## Verification
A status bit that is wrong shows up at the ports in two ways. If its enable and the master enable are set, `irq_o` differs two edges after the event or write that caused it. It is also visible on the next status read. A toggle that is handled wrongly, or a level reassert that is missing, leaves a status word that differs from the XOR-and-OR model kept by the bench, and that word is visible one cycle after the read strobe. A fault in the master-enable gating or in the output register appears as `irq_o` being early, late or stuck, so the bench samples the line both one and two edges after each change.

// File: rtl/ih_pkg.sv
package ih_pkg;
  localparam int unsigned DATA_W   = 32;
  // byte addresses of the three registers
  localparam int unsigned OFF_MEN  = 32'h1C;
  localparam int unsigned OFF_STS  = 32'h20;
  localparam int unsigned OFF_ENA  = 32'h28;
  // master enable bit inside its word
  localparam int unsigned MEN_BIT  = 31;
  // status bit positions decoded by software
  localparam int unsigned B_RX_NE   = 8;
  localparam int unsigned B_RX_FULL = 4;
  localparam int unsigned B_RX_OVR  = 5;
  localparam int unsigned B_TX_EMP  = 2;
  localparam int unsigned B_TX_UND  = 3;
  localparam int unsigned B_TX_HALF = 6;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_MEN  = 2'd1,
    SEL_STS  = 2'd2,
    SEL_ENA  = 2'd3
  } rd_sel_e;
endpackage

// File: rtl/ih_bus_dec.sv
module ih_bus_dec
  import ih_pkg::*;
#(
  parameter int unsigned ADDR_W = 7
) (
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              wr_men_o,
  output logic              wr_sts_o,
  output logic              wr_ena_o,
  output logic              acc_o,
  output rd_sel_e           sel_o
);
  logic hit_men, hit_sts, hit_ena;

  assign hit_men = (addr_i == ADDR_W'(OFF_MEN));
  assign hit_sts = (addr_i == ADDR_W'(OFF_STS));
  assign hit_ena = (addr_i == ADDR_W'(OFF_ENA));

  assign wr_men_o = wr_i & hit_men;
  assign wr_sts_o = wr_i & hit_sts;
  assign wr_ena_o = wr_i & hit_ena;
  assign acc_o    = wr_i | rd_i;

  always_comb begin
    if (hit_men)      sel_o = SEL_MEN;
    else if (hit_sts) sel_o = SEL_STS;
    else if (hit_ena) sel_o = SEL_ENA;
    else              sel_o = SEL_NONE;
  end
endmodule

// File: rtl/ih_status.sv
module ih_status
  import ih_pkg::*;
#(
  parameter int unsigned DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          soft_rst_i,
  input  logic          wr_sts_i,
  input  logic          acc_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] evt_i,
  input  logic          lvl_ne_i,
  input  logic          lvl_full_i,
  output logic [DW-1:0] sts_o
);
  logic [DW-1:0] sts_q, sts_d, lvl_mask;

  always_comb begin
    lvl_mask = '0;
    lvl_mask[B_RX_NE]   = acc_i & lvl_ne_i;
    lvl_mask[B_RX_FULL] = acc_i & lvl_full_i;
  end

  for (genvar i = 0; i < DW; i++) begin : g_bit
    logic tog;
    assign tog      = sts_q[i] ^ (wr_sts_i & wdata_i[i]);
    assign sts_d[i] = tog | evt_i[i] | lvl_mask[i];
  end

  always_ff @(posedge clk) begin
    if (rst || soft_rst_i) sts_q <= '0;
    else                   sts_q <= sts_d;
  end

  assign sts_o = sts_q;

  // R6: an event bit is set after the edge
  p_evt_set_r6: assert property (@(posedge clk) disable iff (rst)
    ((evt_i != '0) && !soft_rst_i) |=> ((sts_q & $past(evt_i)) == $past(evt_i)));
  // R7: rx-not-empty level reasserts on access
  p_lvl_ne_r7: assert property (@(posedge clk) disable iff (rst)
    (acc_i && lvl_ne_i && !soft_rst_i) |=> sts_q[B_RX_NE]);
  p_lvl_full_r7: assert property (@(posedge clk) disable iff (rst)
    (acc_i && lvl_full_i && !soft_rst_i) |=> sts_q[B_RX_FULL]);
  // R10: quiet cycle keeps status
  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (!acc_i && !wr_sts_i && (evt_i == '0) && !soft_rst_i) |=> $stable(sts_q));
endmodule

// File: rtl/ih_cfg.sv
module ih_cfg
  import ih_pkg::*;
#(
  parameter int unsigned DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          soft_rst_i,
  input  logic          wr_men_i,
  input  logic          wr_ena_i,
  input  logic [DW-1:0] wdata_i,
  output logic          men_o,
  output logic [DW-1:0] ena_o
);
  logic          men_q;
  logic [DW-1:0] ena_q;

  always_ff @(posedge clk) begin
    if (rst || soft_rst_i) begin
      men_q <= 1'b0;
      ena_q <= '0;
    end else begin
      if (wr_men_i) men_q <= wdata_i[MEN_BIT];
      if (wr_ena_i) ena_q <= wdata_i;
    end
  end

  assign men_o = men_q;
  assign ena_o = ena_q;

  // R8: soft reset empties configuration
  p_soft_cfg_r8: assert property (@(posedge clk) disable iff (rst)
    soft_rst_i |=> (!men_q && (ena_q == '0)));
endmodule

// File: rtl/ih_gate.sv
module ih_gate
  import ih_pkg::*;
#(
  parameter int unsigned DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] sts_i,
  input  logic [DW-1:0] ena_i,
  input  logic          men_i,
  output logic          irq_o
);
  logic irq_q;

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= men_i & (|(sts_i & ena_i));
  end

  assign irq_o = irq_q;

  // R2: master enable off forces the line low next cycle
  p_men_off_r2: assert property (@(posedge clk) disable iff (rst)
    !men_i |=> !irq_q);
  // R3: nothing pending and enabled gives a low line next cycle
  p_none_pend_r3: assert property (@(posedge clk) disable iff (rst)
    ((sts_i & ena_i) == '0) |=> !irq_q);
  p_pend_r3: assert property (@(posedge clk) disable iff (rst)
    (men_i && ((sts_i & ena_i) != '0)) |=> irq_q);
endmodule

// File: rtl/ih_irq_hub.sv
module ih_irq_hub
  import ih_pkg::*;
#(
  parameter int unsigned ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              soft_rst_i,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  input  logic [31:0]       evt_pulse_i,
  input  logic              rx_nonempty_i,
  input  logic              rx_full_i,
  output logic              irq_o
);
  localparam int unsigned DW = DATA_W;

  logic          wr_men, wr_sts, wr_ena, acc, men;
  rd_sel_e       sel;
  logic [DW-1:0] sts, ena, rd_mux, men_word;

  ih_bus_dec #(.ADDR_W(ADDR_W)) u_dec (
    .wr_i(bus_wr_i), .rd_i(bus_rd_i), .addr_i(bus_addr_i),
    .wr_men_o(wr_men), .wr_sts_o(wr_sts), .wr_ena_o(wr_ena),
    .acc_o(acc), .sel_o(sel)
  );

  ih_status #(.DW(DW)) u_sts (
    .clk(clk), .rst(rst), .soft_rst_i(soft_rst_i),
    .wr_sts_i(wr_sts), .acc_i(acc), .wdata_i(bus_wdata_i),
    .evt_i(evt_pulse_i), .lvl_ne_i(rx_nonempty_i), .lvl_full_i(rx_full_i),
    .sts_o(sts)
  );

  ih_cfg #(.DW(DW)) u_cfg (
    .clk(clk), .rst(rst), .soft_rst_i(soft_rst_i),
    .wr_men_i(wr_men), .wr_ena_i(wr_ena), .wdata_i(bus_wdata_i),
    .men_o(men), .ena_o(ena)
  );

  ih_gate #(.DW(DW)) u_gate (
    .clk(clk), .rst(rst), .sts_i(sts), .ena_i(ena), .men_i(men),
    .irq_o(irq_o)
  );

  always_comb begin
    men_word = '0;
    men_word[MEN_BIT] = men;
    case (sel)
      SEL_MEN: rd_mux = men_word;
      SEL_STS: rd_mux = sts;
      SEL_ENA: rd_mux = ena;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)           bus_rdata_o <= '0;
    else if (bus_rd_i) bus_rdata_o <= rd_mux;
  end

  // R8: soft reset empties the status register
  p_soft_sts_r8: assert property (@(posedge clk) disable iff (rst)
    soft_rst_i |=> (sts == '0));
  // R9: an unmapped read returns zero
  p_unmapped_r9: assert property (@(posedge clk) disable iff (rst)
    (bus_rd_i && (sel == SEL_NONE)) |=> (bus_rdata_o == '0));
endmodule

// File: tb/ih_irq_hub_test.sv
module ih_irq_hub_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        soft_rst_i = 1'b0;
  logic        bus_wr_i = 1'b0;
  logic        bus_rd_i = 1'b0;
  logic [6:0]  bus_addr_i = '0;
  logic [31:0] bus_wdata_i = '0;
  logic [31:0] bus_rdata_o;
  logic [31:0] evt_pulse_i = '0;
  logic        rx_nonempty_i = 1'b0;
  logic        rx_full_i = 1'b0;
  logic        irq_o;

  int n_chk = 0;
  int n_bad = 0;

  localparam logic [6:0] A_MEN = 7'h1C;
  localparam logic [6:0] A_STS = 7'h20;
  localparam logic [6:0] A_ENA = 7'h28;

  always #2 clk = ~clk;

  ih_irq_hub #(.ADDR_W(7)) uut (
    .clk(clk), .rst(rst), .soft_rst_i(soft_rst_i),
    .bus_wr_i(bus_wr_i), .bus_rd_i(bus_rd_i), .bus_addr_i(bus_addr_i),
    .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o),
    .evt_pulse_i(evt_pulse_i), .rx_nonempty_i(rx_nonempty_i),
    .rx_full_i(rx_full_i), .irq_o(irq_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
    @(negedge clk);
    bus_wr_i = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd_i = 1'b1; bus_addr_i = a;
    @(negedge clk);
    bus_rd_i = 1'b0;
    d = bus_rdata_o;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    check("R1 irq", {31'b0, irq_o}, 32'h0);
    rd(A_STS, v); check("R1 status", v, 32'h0);
    rd(A_ENA, v); check("R1 enable", v, 32'h0);
    rd(A_MEN, v); check("R1 master", v, 32'h0);
  endtask

  task automatic t_regs;
    logic [31:0] v;
    wr(A_MEN, 32'hFFFF_FFFF);
    rd(A_MEN, v); check("R2 master bit only", v, 32'h8000_0000);
    wr(A_ENA, 32'hA5C3_0F71);
    rd(A_ENA, v); check("R5 enable readback", v, 32'hA5C3_0F71);
    wr(A_MEN, 32'h7FFF_FFFF);
    rd(A_MEN, v); check("R2 master cleared", v, 32'h0);
    wr(A_ENA, 32'h0);
  endtask

  task automatic t_toggle;
    logic [31:0] v;
    wr(A_STS, 32'h0000_0024);
    rd(A_STS, v); check("R4 toggle set", v, 32'h24);
    wr(A_STS, 32'h0000_000C);
    rd(A_STS, v); check("R4 toggle flip", v, 32'h28);
    wr(A_STS, 32'h0000_0028);
    rd(A_STS, v); check("R4 toggle back to 0", v, 32'h0);
  endtask

  task automatic t_irq;
    logic [31:0] v;
    wr(A_STS, 32'h0000_0020);        // rx-overrun bit 5
    wr(A_MEN, 32'h8000_0000);
    wr(A_ENA, 32'h0000_0020);        // enable lands on this edge
    check("R3 irq not yet", {31'b0, irq_o}, 32'h0);
    @(negedge clk);
    check("R3 irq one clock later", {31'b0, irq_o}, 32'h1);
    // R10: quiet cycles hold everything
    repeat (6) @(negedge clk);
    check("R10 irq held", {31'b0, irq_o}, 32'h1);
    rd(A_STS, v); check("R10 status held", v, 32'h20);
    wr(A_MEN, 32'h0);
    check("R2 irq before gate takes effect", {31'b0, irq_o}, 32'h1);
    @(negedge clk);
    check("R2 master off forces low", {31'b0, irq_o}, 32'h0);
    wr(A_MEN, 32'h8000_0000);
    @(negedge clk);
    check("R3 irq restored", {31'b0, irq_o}, 32'h1);
    wr(A_STS, 32'h0000_0020);
    @(negedge clk);
    check("R3 irq drops after toggle clear", {31'b0, irq_o}, 32'h0);
  endtask

  task automatic t_event;
    logic [31:0] v;
    @(negedge clk);
    evt_pulse_i = 32'h0000_0004;     // tx-empty bit 2
    @(negedge clk);
    evt_pulse_i = '0;
    repeat (4) @(negedge clk);
    rd(A_STS, v); check("R6 event sticky", v, 32'h4);
    wr(A_STS, 32'h0000_0008);        // bit 3 set by toggle
    @(negedge clk);
    bus_wr_i = 1'b1; bus_addr_i = A_STS; bus_wdata_i = 32'h0000_0008;
    evt_pulse_i = 32'h0000_0008;     // tx-underrun hits same bit
    @(negedge clk);
    bus_wr_i = 1'b0; evt_pulse_i = '0;
    rd(A_STS, v); check("R6 event beats toggle", v, 32'h0C);
    wr(A_STS, 32'h0000_000C);
    rd(A_STS, v); check("R6 cleared", v, 32'h0);
  endtask

  task automatic t_level;
    logic [31:0] v;
    rx_nonempty_i = 1'b1;
    repeat (3) @(negedge clk);
    wr(A_ENA, 32'h0);                // access elsewhere reasserts bit 8
    rx_nonempty_i = 1'b0;
    rd(A_STS, v); check("R7 not-empty set on access", v, 32'h100);
    rx_nonempty_i = 1'b1; rx_full_i = 1'b1;
    wr(A_STS, 32'h0000_0100);        // clear attempt while level high
    rd(A_STS, v); check("R7 clear defeated and full set", v, 32'h110);
    rx_nonempty_i = 1'b0; rx_full_i = 1'b0;
    wr(A_STS, 32'h0000_0110);
    rd(A_STS, v); check("R7 clears once levels drop", v, 32'h0);
  endtask

  task automatic t_unmapped;
    logic [31:0] v;
    wr(A_ENA, 32'h1234_5678);
    rd(7'h40, v); check("R9 unmapped reads 0", v, 32'h0);
    rd(7'h29, v); check("R9 misaligned reads 0", v, 32'h0);
    rd(A_ENA, v); check("R9 registered read data", v, 32'h1234_5678);
  endtask

  task automatic t_soft;
    logic [31:0] v;
    wr(A_ENA, 32'h0000_0040);
    wr(A_MEN, 32'h8000_0000);
    @(negedge clk);
    evt_pulse_i = 32'h0000_0040;
    @(negedge clk);
    evt_pulse_i = '0;
    @(negedge clk);
    check("R8 irq high before soft reset", {31'b0, irq_o}, 32'h1);
    soft_rst_i = 1'b1; evt_pulse_i = 32'h0000_0040;
    @(negedge clk);
    soft_rst_i = 1'b0; evt_pulse_i = '0;
    @(negedge clk);
    check("R8 irq low after soft reset", {31'b0, irq_o}, 32'h0);
    rd(A_STS, v); check("R8 status cleared", v, 32'h0);
    rd(A_ENA, v); check("R8 enable cleared", v, 32'h0);
    rd(A_MEN, v); check("R8 master cleared", v, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_regs();
    t_toggle();
    t_irq();
    t_event();
    t_level();
    t_unmapped();
    t_soft();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule